// File: doc/BRIEF.md
# Reset and Power-Fail Supervisor

This block builds the system reset for a board-level controller and handles the switch to a backup supply. It takes two clean flags from analog comparators elsewhere: a low-supply flag and a standby-switchover flag. It also takes a raw, bouncing external reset request from a pushbutton or a similar source.

The external request passes through a synchronizer and a stable-level filter before it can act. Each reset cause produces a reset output. That output is stretched to a programmable number of clocks after the last cause goes away, and it is driven with a programmable polarity. The causes are low supply, an invalid configuration, and a filtered external request.

The switchover flag acts at once with no clock in the path. It blocks every write strobe toward the internal SRAM. It also forces one selectable chip select, an active-low output, to its inactive level. That chip select can guard a battery-backed external SRAM or a flash device against stray writes while power fails.

Top module: `pwr_rst_supervisor`

## Requirements
- R1: The reset is active while rst_ni is low and while cfg_valid_i is low. Active means sys_rst_o equals cfg_rst_high_i.
- R2: When low_supply_i is high at a rising clock edge, the reset is active from that edge on.
- R3: Let L be cfg_rst_len_i. After the first rising edge at which no cause is present, the reset stays active for exactly L further edges and is released at the edge after those. With L = 0 it is released at that first cause-free edge.
- R4: A cause that appears again while the reset is being stretched restarts the stretch, so the reset is released only L+1 edges after the last cause ends.
- R5: sys_rst_o is high for an active reset when cfg_rst_high_i = 1 and low when cfg_rst_high_i = 0. A change of cfg_rst_high_i takes effect without a clock.
- R6: ext_rst_i is active high. It passes a two-stage synchronizer, and the filter accepts a new level only after the synchronized input has differed from the accepted level for N consecutive edges. N is cfg_db_len_i, and 0 counts as 1. A press held steady makes the reset active N+3 edges after ext_rst_i rises.
- R7: An external pulse held for fewer than N clock periods never activates the reset.
- R8: sram_we_o follows sram_we_i while standby_i is low and is 0 while standby_i is high, with no clock delay.
- R9: While standby_i is high, bit cs_sel_i of cs_n_o is 1 (inactive) regardless of cs_n_i, without a clock delay. All other bits of cs_n_o pass cs_n_i unchanged, and all bits pass unchanged while standby_i is low.
- R10: Releasing a filtered external request gives the full stretch. The reset is released N+L+3 edges after ext_rst_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| cfg_valid_i | input | 1 | Configuration valid; low holds the reset active |
| cfg_rst_high_i | input | 1 | 1: sys_rst_o active high, 0: active low |
| cfg_db_len_i | input | DB_W | Filter length N in clocks (0 treated as 1) |
| cfg_rst_len_i | input | LEN_W | Stretch length L in clocks |
| low_supply_i | input | 1 | Low-supply flag from comparator |
| standby_i | input | 1 | Backup-supply switchover flag |
| ext_rst_i | input | 1 | Raw external reset request, active high |
| sram_we_i | input | 1 | SRAM write strobe from the bus |
| sram_we_o | output | 1 | Gated SRAM write strobe |
| cs_n_i | input | NUM_CS | Active-low chip selects from decode |
| cs_sel_i | input | CS_SEL_W | Index of the chip select killed on switchover |
| cs_n_o | output | NUM_CS | Active-low chip selects to the pins |
| sys_rst_o | output | 1 | System reset with programmed polarity |

## Verification
The bench builds the block with NUM_CS = 4, DB_W = 4 and LEN_W = 5, and it runs with a filter length of 3 and stretch lengths of 4 and 0. With these short values, exact edge counts can be checked for press acceptance, rejection of a pulse one clock too short, stretch release and retrigger, all inside a few dozen cycles. Four chip selects let the bench show that the killed bit moves with cs_sel_i while the neighbouring bits keep the values that drive them.

// File: rtl/rst_sup_pkg.sv
`timescale 1ns/1ps
package rst_sup_pkg;
  typedef enum logic {
    BTN_IDLE = 1'b0,
    BTN_HELD = 1'b1
  } btn_e;

  localparam int MinSyncStages = 1;
endpackage

// File: rtl/ext_rst_filter.sv
`timescale 1ns/1ps
module ext_rst_filter
  import rst_sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             held_o
);
  localparam int Stages = (SYNC_STAGES < MinSyncStages) ? MinSyncStages : SYNC_STAGES;

  logic [Stages-1:0] sync_q;
  logic              samp;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lim_m1;
  btn_e              state_q;

  generate
    if (Stages == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= raw_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[Stages-2:0], raw_i};
      end
    end
  endgenerate

  assign samp   = sync_q[Stages-1];
  // zero length behaves as one
  assign lim_m1 = (len_i == '0) ? '0 : len_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BTN_IDLE;
      cnt_q   <= '0;
    end else if (samp != logic'(state_q)) begin
      if (cnt_q == lim_m1) begin
        state_q <= btn_e'(samp);
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign held_o = (state_q == BTN_HELD);
endmodule

// File: rtl/rst_stretch.sv
`timescale 1ns/1ps
module rst_stretch #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cause_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             act_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             act_q;

  // reload while any cause is present; count down once all are gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (cause_i) begin
      cnt_q <= len_i;
      act_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      act_q <= 1'b1;
    end else begin
      act_q <= 1'b0;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/standby_guard.sv
`timescale 1ns/1ps
module standby_guard #(
  parameter int NUM_CS   = 4,
  parameter int CS_SEL_W = 2
) (
  input  logic                standby_i,
  input  logic                we_i,
  output logic                we_o,
  input  logic [NUM_CS-1:0]   cs_n_i,
  input  logic [CS_SEL_W-1:0] sel_i,
  output logic [NUM_CS-1:0]   cs_n_o
);
  assign we_o = we_i & ~standby_i;

  // purely combinational: no clock between the flag and the pins
  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign cs_n_o[g] = cs_n_i[g] | (standby_i & (sel_i == CS_SEL_W'(g)));
    end
  endgenerate
endmodule

// File: rtl/pwr_rst_supervisor.sv
`timescale 1ns/1ps
module pwr_rst_supervisor #(
  parameter int NUM_CS      = 4,
  parameter int CS_SEL_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  parameter int DB_W        = 8,
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_valid_i,
  input  logic                cfg_rst_high_i,
  input  logic [DB_W-1:0]     cfg_db_len_i,
  input  logic [LEN_W-1:0]    cfg_rst_len_i,
  input  logic                low_supply_i,
  input  logic                standby_i,
  input  logic                ext_rst_i,
  input  logic                sram_we_i,
  output logic                sram_we_o,
  input  logic [NUM_CS-1:0]   cs_n_i,
  input  logic [CS_SEL_W-1:0] cs_sel_i,
  output logic [NUM_CS-1:0]   cs_n_o,
  output logic                sys_rst_o
);
  logic ext_held;
  logic rst_cause;
  logic rst_act;

  ext_rst_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (DB_W)
  ) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (ext_rst_i),
    .len_i (cfg_db_len_i),
    .held_o(ext_held)
  );

  assign rst_cause = low_supply_i | ~cfg_valid_i | ext_held;

  rst_stretch #(
    .LEN_W(LEN_W)
  ) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cause_i(rst_cause),
    .len_i  (cfg_rst_len_i),
    .act_o  (rst_act)
  );

  assign sys_rst_o = cfg_rst_high_i ? rst_act : ~rst_act;

  standby_guard #(
    .NUM_CS  (NUM_CS),
    .CS_SEL_W(CS_SEL_W)
  ) u_guard (
    .standby_i(standby_i),
    .we_i     (sram_we_i),
    .we_o     (sram_we_o),
    .cs_n_i   (cs_n_i),
    .sel_i    (cs_sel_i),
    .cs_n_o   (cs_n_o)
  );
endmodule

// File: rtl/pwr_rst_supervisor_chk.sv
`timescale 1ns/1ps
module pwr_rst_supervisor_chk #(
  parameter int NUM_CS   = 4,
  parameter int CS_SEL_W = 2,
  parameter int LEN_W    = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_valid_i,
  input logic [LEN_W-1:0]    cfg_rst_len_i,
  input logic                low_supply_i,
  input logic                standby_i,
  input logic                sram_we_o,
  input logic [NUM_CS-1:0]   cs_n_o,
  input logic [CS_SEL_W-1:0] cs_sel_i,
  input logic                cause,
  input logic                act
);
  logic [LEN_W:0] quiet_q;

  // edges seen with no cause, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                quiet_q <= '0;
    else if (cause)             quiet_q <= '0;
    else if (quiet_q != '1)     quiet_q <= quiet_q + 1'b1;
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_i |=> act); // R1

  AST_LOW_SUPPLY_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_supply_i |=> act); // R2

  AST_FULL_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act) |-> (quiet_q == ({1'b0, cfg_rst_len_i} + 1'b1))); // R3

  AST_RETRIGGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && cause) |=> act); // R4

  always_comb begin
    if (rst_ni && standby_i) begin
      AST_SRAM_LOCK: assert (!sram_we_o); // R8
    end
  end

  always_comb begin
    if (rst_ni && standby_i && (int'(cs_sel_i) < NUM_CS)) begin
      AST_CS_KILL: assert (cs_n_o[cs_sel_i]); // R9
    end
  end
endmodule

bind pwr_rst_supervisor pwr_rst_supervisor_chk #(
  .NUM_CS  (NUM_CS),
  .CS_SEL_W(CS_SEL_W),
  .LEN_W   (LEN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_valid_i  (cfg_valid_i),
  .cfg_rst_len_i(cfg_rst_len_i),
  .low_supply_i (low_supply_i),
  .standby_i    (standby_i),
  .sram_we_o    (sram_we_o),
  .cs_n_o       (cs_n_o),
  .cs_sel_i     (cs_sel_i),
  .cause        (rst_cause),
  .act          (rst_act)
);

// File: tb/pwr_rst_supervisor_test.sv
`timescale 1ns/1ps
module pwr_rst_supervisor_test;
  localparam int NUM_CS = 4;
  localparam int SEL_W  = 2;
  localparam int DB_W   = 4;
  localparam int LEN_W  = 5;
  localparam int N      = 3;
  localparam int L      = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              cfg_valid_i, cfg_rst_high_i;
  logic [DB_W-1:0]   cfg_db_len_i;
  logic [LEN_W-1:0]  cfg_rst_len_i;
  logic              low_supply_i, standby_i, ext_rst_i, sram_we_i;
  logic              sram_we_o, sys_rst_o;
  logic [NUM_CS-1:0] cs_n_i, cs_n_o;
  logic [SEL_W-1:0]  cs_sel_i;

  always #10 clk_i = ~clk_i;

  pwr_rst_supervisor #(
    .NUM_CS(NUM_CS), .CS_SEL_W(SEL_W), .DB_W(DB_W), .LEN_W(LEN_W), .SYNC_STAGES(2)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_valid_i(cfg_valid_i),
    .cfg_rst_high_i(cfg_rst_high_i), .cfg_db_len_i(cfg_db_len_i),
    .cfg_rst_len_i(cfg_rst_len_i), .low_supply_i(low_supply_i),
    .standby_i(standby_i), .ext_rst_i(ext_rst_i), .sram_we_i(sram_we_i),
    .sram_we_o(sram_we_o), .cs_n_i(cs_n_i), .cs_sel_i(cs_sel_i),
    .cs_n_o(cs_n_o), .sys_rst_o(sys_rst_o)
  );

  // sig: 0 sys_rst_o, 1 sram_we_o, 2 cs_n_o
  typedef struct {
    int         cyc;
    int         sig;
    logic [7:0] val;
    string      req;
  } exp_t;

  exp_t q[$];
  int   cyc    = 0;
  int   checks = 0;
  int   errs   = 0;
  bit   done   = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: pop items due this cycle and compare
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      logic [7:0] act;
      e = q.pop_front();
      case (e.sig)
        0:       act = {7'd0, sys_rst_o};
        1:       act = {7'd0, sram_we_o};
        default: act = {4'd0, cs_n_o};
      endcase
      checks++;
      if (e.cyc != cyc || act !== e.val) begin
        errs++;
        $display("FAIL %s: sig %0d cycle %0d actual %0h expected %0h (due %0d)",
                 e.req, e.sig, cyc, act, e.val, e.cyc);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  // driver side: push expectation k posedges ahead, kept in cycle order
  task automatic expect_at(input int k, input int sig, input logic [7:0] val, input string req);
    exp_t e;
    int   pos;
    e.cyc = cyc + k; e.sig = sig; e.val = val; e.req = req;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > e.cyc) begin
        pos = i;
        break;
      end
    end
    q.insert(pos, e);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; cfg_valid_i = 0; cfg_rst_high_i = 1;
    cfg_db_len_i = DB_W'(N); cfg_rst_len_i = LEN_W'(L);
    low_supply_i = 0; standby_i = 0; ext_rst_i = 0; sram_we_i = 0;
    cs_n_i = '0; cs_sel_i = '0;

    // R1: power-on and invalid configuration
    step(1); expect_at(0, 0, 8'd1, "R1");
    step(2); rst_ni = 1; expect_at(0, 0, 8'd1, "R1");
    step(3); expect_at(0, 0, 8'd1, "R1");
    cfg_valid_i = 1;
    expect_at(L, 0, 8'd1, "R3");
    expect_at(L + 1, 0, 8'd0, "R3");
    step(L + 3);

    // R2 then R3 stretch
    low_supply_i = 1;
    expect_at(0, 0, 8'd0, "R2");
    expect_at(1, 0, 8'd1, "R2");
    step(3); low_supply_i = 0;
    expect_at(L, 0, 8'd1, "R3");
    expect_at(L + 1, 0, 8'd0, "R3");
    step(L + 3);

    // R3 zero length
    cfg_rst_len_i = '0; low_supply_i = 1;
    step(2); low_supply_i = 0;
    expect_at(0, 0, 8'd1, "R3");
    expect_at(1, 0, 8'd0, "R3");
    step(3); cfg_rst_len_i = LEN_W'(L);

    // R4 retrigger mid-stretch
    low_supply_i = 1; step(1); low_supply_i = 0;
    step(2); expect_at(0, 0, 8'd1, "R4");
    low_supply_i = 1; step(1); low_supply_i = 0;
    expect_at(L, 0, 8'd1, "R4");
    expect_at(L + 1, 0, 8'd0, "R4");
    step(L + 3);

    // R5 active-low polarity
    cfg_rst_high_i = 0; expect_at(0, 0, 8'd1, "R5");
    low_supply_i = 1; expect_at(1, 0, 8'd0, "R5");
    step(2); low_supply_i = 0;
    expect_at(L + 1, 0, 8'd1, "R5");
    step(L + 3);
    cfg_rst_high_i = 1; expect_at(0, 0, 8'd0, "R5");
    step(1);

    // R6 press, R10 release
    ext_rst_i = 1;
    expect_at(N + 2, 0, 8'd0, "R6");
    expect_at(N + 3, 0, 8'd1, "R6");
    step(N + 6);
    ext_rst_i = 0;
    expect_at(N + L + 2, 0, 8'd1, "R10");
    expect_at(N + L + 3, 0, 8'd0, "R10");
    step(N + L + 5);

    // R7 pulse one clock too short
    ext_rst_i = 1; step(N - 1); ext_rst_i = 0;
    expect_at(2, 0, 8'd0, "R7");
    expect_at(N + 4, 0, 8'd0, "R7");
    step(N + 6);
    // R6 pulse of exactly N clocks is accepted
    ext_rst_i = 1; step(N); ext_rst_i = 0;
    expect_at(2, 0, 8'd0, "R6");
    expect_at(3, 0, 8'd1, "R6");
    step(N + L + 8);
    expect_at(0, 0, 8'd0, "R6");
    step(1);

    // R8, R9 switchover
    sram_we_i = 1; cs_n_i = 4'b0000; cs_sel_i = 2'd2;
    expect_at(0, 1, 8'd1, "R8");
    expect_at(0, 2, 8'h0, "R9");
    step(1);
    standby_i = 1;
    expect_at(0, 1, 8'd0, "R8");
    expect_at(0, 2, 8'h4, "R9");
    expect_at(0, 0, 8'd0, "R9");
    step(1);
    cs_sel_i = 2'd0; expect_at(0, 2, 8'h1, "R9");
    step(1);
    cs_n_i = 4'b1010; cs_sel_i = 2'd2; expect_at(0, 2, 8'hE, "R9");
    step(1);
    standby_i = 0;
    expect_at(0, 1, 8'd1, "R8");
    expect_at(0, 2, 8'hA, "R9");
    step(2);

    if (q.size() != 0) begin
      errs++;
      checks++;
      $display("FAIL queue: actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule